// File: doc/BRIEF.md
# LC Oscillator Coarse-Tune Calibration Engine

This engine chooses the coarse frequency-band code of an LC oscillator before the fine-tuning loop takes over. On a start request it sets the highest-frequency code. It lets the oscillator settle, then counts reference edges and feedback edges over one shared window. If the feedback clock is still faster than the reference, it steps the code down by one and repeats the trial. It stops at the first code whose feedback count does not exceed the reference count.

The reference clock may carry downward spread-spectrum modulation. For that reason the window length is set in reference edges by an input, and the system programs it to cover exactly one modulation period at the current reference rate. The modulation then averages out of every trial, so the chosen code does not depend on where in the modulation cycle a trial falls, and codes stay monotonic. Reference edges arrive as a one-cycle qualifier in the engine's clock domain. Feedback edges arrive as a toggle that may be asynchronous to that domain; the engine synchronizes it and turns each change into one edge.

Top module: `cal_coarse_tune`

## Requirements
- R1: After reset the code output is all ones (31), and busy, done and fail are low.
- R2: A start pulse while idle raises busy on the next cycle, clears done and fail, and loads code 31.
- R3: Each trial holds the code for a settle interval of settleLen+1 cycles. It then clears both counters together and counts for a window that ends on the winLen-th reference edge. It then spends one cycle comparing the counts.
- R4: Every change of level on fbToggle is counted as one feedback edge after a multi-flop synchronizer. The feedback count saturates at its maximum and does not wrap.
- R5: When the feedback count is less than or equal to the reference count, the search stops. done rises, busy falls, and the code of that trial stays on the output.
- R6: Codes are tried strictly in descending order. Between trials the code drops by exactly one.
- R7: If code 0 still gives a feedback count above the reference count, fail rises, busy falls and code 0 stays on the output.
- R8: A start pulse while busy has no effect. The running search neither restarts nor changes length.
- R9: done and fail are never high together or while busy. Each stays high, with the code unchanged, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run a calibration |
| winLen | input | CNT_W | Window length in reference edges (one modulation period) |
| settleLen | input | CNT_W | Settle wait after each code change, in clock cycles, minus one |
| refEdge | input | 1 | One-cycle qualifier marking a reference edge |
| fbToggle | input | 1 | Feedback divider toggle, asynchronous, one change per edge |
| coarseCode | output | CODE_W | Coarse-tune code driven to the oscillator band DAC |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration found a crossing code |
| fail | output | 1 | No crossing found down to code 0 |

## Verification
An oscillator model in the bench turns the current code into a feedback edge rate. The crossing falls 8/1024 on either side of the reference rate, so the correct code is clear even with synchronizer jitter. The crossing is placed at the first code tried, in mid-range, at the last code, and nowhere (the exhaustion path). These runs separate a correct stop from an off-by-one in the compare, a wrong search direction, or a wrong floor. Busy time is compared against the number of trials times the settle-plus-window length, for two window and settle settings. This catches a skipped settle, a window that ignores its programmed length, and a restart from a second start pulse during a run.

// File: rtl/cal_coarse_pkg.sv
package cal_coarse_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_COUNT  = 2'd2,
    ST_EVAL   = 2'd3
  } calState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;   // clear both counters together
    logic countEn;  // measurement window is open
  } calStrobe_t;

endpackage

// File: rtl/cal_edge_sync.sv
module cal_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncToggle,
  output logic edgePulse
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[CHAIN_W-2:0], asyncToggle};
  end

  // Oldest bit holds last synchronized level; a difference is one edge
  assign edgePulse = chain[CHAIN_W-1] ^ chain[CHAIN_W-2];

endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_coarse_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  calStrobe_t       strobe,
  input  logic             refEdge,
  input  logic             fbEdge,
  input  logic [CNT_W-1:0] winLen,
  output logic             winEnd,
  output logic             fbNotAbove
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] refCnt;
  logic [CNT_W-1:0] fbCnt;
  logic [CNT_W:0]   refNext;

  assign refNext = {1'b0, refCnt} + {{CNT_W{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
      fbCnt  <= '0;
    end else if (strobe.clrCnt) begin
      refCnt <= '0;
      fbCnt  <= '0;
    end else if (strobe.countEn) begin
      if (refEdge) refCnt <= refNext[CNT_W-1:0];
      if (fbEdge && (fbCnt != CNT_MAX)) fbCnt <= fbCnt + 1'b1;
    end
  end

  // Window closes on the winLen-th reference edge (zero behaves as one)
  assign winEnd     = strobe.countEn && refEdge && (refNext >= {1'b0, winLen});
  assign fbNotAbove = (fbCnt <= refCnt);

  // R4: feedback counter saturates instead of wrapping
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && !strobe.clrCnt && fbCnt == CNT_MAX) |=> (fbCnt == CNT_MAX));

  // R3: both counters start each window from zero
  p_clear_together_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCnt |=> (refCnt == '0 && fbCnt == '0));

  // R3: reference count never runs past the programmed window
  p_window_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && winLen != '0) |-> (refCnt < winLen));

endmodule

// File: rtl/cal_control.sv
module cal_control
  import cal_coarse_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  settleLen,
  input  logic              winEnd,
  input  logic              fbNotAbove,
  output calStrobe_t        strobe,
  output logic [CODE_W-1:0] code,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  localparam logic [CODE_W-1:0] CODE_TOP = '1;
  localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

  calState_t        state;
  logic [CNT_W-1:0] settleCnt;

  always_comb begin
    strobe.clrCnt  = (state == ST_SETTLE) && (settleCnt == '0);
    strobe.countEn = (state == ST_COUNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
      code      <= CODE_TOP;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_SETTLE;
            settleCnt <= settleLen;
            code      <= CODE_TOP;
            busy      <= 1'b1;
            done      <= 1'b0;
            fail      <= 1'b0;
          end
        end
        ST_SETTLE: begin
          if (settleCnt == '0) state <= ST_COUNT;
          else                 settleCnt <= settleCnt - 1'b1;
        end
        ST_COUNT: begin
          if (winEnd) state <= ST_EVAL;
        end
        ST_EVAL: begin
          if (fbNotAbove) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else if (code == '0) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            fail  <= 1'b1;
          end else begin
            state     <= ST_SETTLE;
            settleCnt <= settleLen;
            code      <= code - CODE_ONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: status flags exclusive
  p_status_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busy, done, fail}));

  // R6: during a search the code only holds or drops by one
  p_code_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy) |-> (code == $past(code) || code == $past(code) - CODE_ONE));

  // R7: fail only at the bottom code
  p_fail_floor_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> (code == '0));

  // R9: idle code holds until a start
  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(code));

  // R2: start from idle raises busy at the top code
  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && code == CODE_TOP));

endmodule

// File: rtl/cal_coarse_tune.sv
module cal_coarse_tune
  import cal_coarse_pkg::*;
#(
  parameter int CODE_W      = 5,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  winLen,
  input  logic [CNT_W-1:0]  settleLen,
  input  logic              refEdge,
  input  logic              fbToggle,
  output logic [CODE_W-1:0] coarseCode,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  calStrobe_t strobe;
  logic       fbEdge;
  logic       winEnd;
  logic       fbNotAbove;

  cal_edge_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncToggle(fbToggle), .edgePulse(fbEdge)
  );

  cal_datapath #(.CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .refEdge(refEdge),
    .fbEdge(fbEdge), .winLen(winLen), .winEnd(winEnd), .fbNotAbove(fbNotAbove)
  );

  cal_control #(.CODE_W(CODE_W), .CNT_W(CNT_W)) uCtl (
    .clk(clk), .rstN(rstN), .start(start), .settleLen(settleLen),
    .winEnd(winEnd), .fbNotAbove(fbNotAbove), .strobe(strobe),
    .code(coarseCode), .busy(busy), .done(done), .fail(fail)
  );

endmodule

// File: tb/sim_cal_coarse_tune.sv
module sim_cal_coarse_tune;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] winLen = 16'd500;
  logic [15:0] settleLen = 16'd20;
  logic        refEdge = 1'b0;
  logic        fbToggle = 1'b0;
  logic [4:0]  coarseCode;
  logic        busy, done, fail;

  int errors = 0;
  int checks = 0;
  int crossX = 31;
  bit failMode = 1'b0;
  int acc = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [4:0]  code;
    logic        done;
    logic        fail;
    logic [31:0] lo;
    logic [31:0] hi;
  } expItem_t;

  expItem_t expQ[$];

  cal_coarse_tune u0 (
    .clk(clk), .rstN(rstN), .start(start), .winLen(winLen),
    .settleLen(settleLen), .refEdge(refEdge), .fbToggle(fbToggle),
    .coarseCode(coarseCode), .busy(busy), .done(done), .fail(fail)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Oscillator model: reference edge every other cycle (rate 512/1024),
  // feedback rate per code crosses the reference between crossX and crossX+1
  function automatic int fbRate(input int c);
    int r;
    if (failMode) return 700;
    r = 512 + 16 * (c - crossX) - 8;
    if (r < 0) r = 0;
    if (r > 1000) r = 1000;
    return r;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      refEdge = ~refEdge;
      acc = acc + fbRate(int'(coarseCode));
      if (acc >= 1024) begin
        acc = acc - 1024;
        fbToggle = ~fbToggle;
      end
    end
  end

  // Monitor: measures each busy interval and compares against the queue
  initial begin
    forever begin
      int dur;
      expItem_t e;
      @(negedge clk);
      if (busy) begin
        dur = 0;
        while (busy) begin
          dur++;
          @(negedge clk);
        end
        if (expQ.size() == 0) begin
          chk(1'b0, "R8 unexpected run", dur, 0);
        end else begin
          e = expQ.pop_front();
          chk(coarseCode == e.code, "R5/R6/R7 code", int'(coarseCode), int'(e.code));
          chk(done == e.done, "R5 done", int'(done), int'(e.done));
          chk(fail == e.fail, "R7 fail", int'(fail), int'(e.fail));
          chk(dur >= int'(e.lo) && dur <= int'(e.hi), "R3/R8 busy length",
              dur, int'(e.lo));
        end
      end
    end
  end

  // Driver: push expectation, start, check R2, optionally re-start (R8)
  task automatic runCal(input int x, input bit isFail, input int w, input int s,
                        input bit extraStart);
    expItem_t e;
    int n;
    crossX   = x;
    failMode = isFail;
    winLen   = 16'(w);
    settleLen = 16'(s);
    n = isFail ? 32 : 32 - x;
    e.code = isFail ? 5'd0 : 5'(x);
    e.done = !isFail;
    e.fail = isFail;
    e.lo   = 32'(n * (s + 2 * w + 1));
    e.hi   = 32'(n * (s + 2 * w + 2) + 1);
    expQ.push_back(e);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy", int'(busy), 1);
    chk(coarseCode == 5'd31, "R2 top code", int'(coarseCode), 31);
    chk(done == 1'b0 && fail == 1'b0, "R2 clear", int'({done, fail}), 0);
    if (extraStart) begin
      repeat (3 * w) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy || expQ.size() != 0) @(negedge clk);
    repeat (25) @(negedge clk);
    // R9: result held while idle
    chk(coarseCode == e.code, "R9 code held", int'(coarseCode), int'(e.code));
    chk(done == e.done && fail == e.fail, "R9 flags held",
        int'({done, fail}), int'({e.done, e.fail}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(coarseCode == 5'd31, "R1 code", int'(coarseCode), 31);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(fail == 1'b0, "R1 fail", int'(fail), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    runCal(31, 1'b0, 500, 20, 1'b0);  // R5: first code already crosses
    runCal(17, 1'b0, 500, 20, 1'b1);  // R6, R8: mid-range, extra start
    runCal(0,  1'b0, 500, 20, 1'b0);  // R6: crossing at the last code
    runCal(0,  1'b1, 500, 20, 1'b0);  // R7: no crossing
    runCal(25, 1'b0, 300, 60, 1'b0);  // R3, R4: other window and settle
    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 190000) begin
      @(negedge clk);
      cyc++;
    end
    if (!finished) chk(1'b0, "watchdog", cyc, 190000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule